// File: doc/BRIEF.md
# Smart card activation sequencer

This block brings a smart card contact interface up and down under the control of a host. The host asks for a session by pulling an active-low session command low. The block then switches on the card supply and waits for an external comparator to confirm the supply is stable. It then enables the card data and auxiliary lines, opens the card clock gate and finally hands the card reset line over to the host. Dropping the session command, or losing the supply-good indication, runs the same steps in reverse.

A second way to start the clock is available for hosts that need to count clock cycles exactly before the answer-to-reset. If the host reset input is high when the session starts, the card clock starts on the falling edge of host reset, provided that edge falls inside a window that opens when the data lines come up. The card reset stays low until the window closes and copies the host reset after that. All asynchronous inputs pass through two-flop synchronizers. Every delay is a parameter counted in system clock cycles.

Top module: `sc_act_seq`

## Requirements
- R1: While reset is asserted and after it is released with no session requested, the supply enable, line enable, clock gate and card reset outputs are all low.
- R2: Outside a session, the status output equals the synchronized card-presence input (1 = card present), and it follows a change on that input two clock cycles later.
- R3: A session starts only when card presence is high and the session command is low. The supply enable rises three cycles after both conditions hold. With no card present it stays low.
- R4: Once the supply enable is high, the line enable rises three cycles after the supply-stable input rises. Until then, the clock gate and card reset stay low.
- R5: Normal mode (host reset low when the supply enable rises): the clock gate rises CLK_DLY_CYC cycles after the line enable. The card reset driver is enabled RST_DLY_CYC cycles after the clock gate rises. From then on, card reset equals host reset delayed by three cycles.
- R6: Clock-start mode (host reset high when the supply enable rises): a falling edge of host reset starts the clock three cycles later. This holds when the clock would start no later than WIN_CYC cycles after the line enable rose.
- R7: In clock-start mode with no qualifying falling edge, the clock gate rises exactly WIN_CYC cycles after the line enable.
- R8: In clock-start mode the card reset is low until WIN_CYC cycles after the line enable. After that it equals host reset delayed by three cycles, and host reset no longer changes the clock gate.
- R9: At all times, a high clock gate implies a high line enable, a high line enable implies a high supply enable, and a high card reset implies a high clock gate.
- R10: The session command going high starts deactivation three cycles later with card reset low. The clock gate falls STEP_CYC cycles after that, the line enable falls 2*STEP_CYC cycles after it, and the supply enable falls 3*STEP_CYC cycles after it.
- R11: Supply-good going low during a session runs the same deactivation with the same timing, and the status output goes low as it starts. Status stays low, and no new session starts, until the session command has been seen high. Status then shows card presence three cycles after the command rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| card_present_i | input | 1 | Card presence, asynchronous, high = present |
| sess_cmd_ni | input | 1 | Session command from host, active low, asynchronous |
| supply_good_i | input | 1 | Supply-good from external comparator, asynchronous |
| host_rst_i | input | 1 | Host reset level, asynchronous |
| vcc_stable_i | input | 1 | Card supply has reached its programmed level, asynchronous |
| vcc_en_o | output | 1 | Card supply enable |
| io_en_o | output | 1 | Enable for card data and auxiliary lines |
| clk_gate_o | output | 1 | Card clock gate |
| card_rst_o | output | 1 | Card reset line |
| host_stat_o | output | 1 | Status/interrupt to the host |

## Verification
The bench measures each step of activation and deactivation to the exact cycle. A counter that is off by one, or a missing synchronizer stage, therefore shows up as an early or late edge. In clock-start mode it places the host reset edge at the very opening of the window, in the middle, at the last position that still counts, and not at all. A design that ignored the window would leave the card unclocked, and one that compared the window end wrongly would start the clock a cycle off. It raises host reset again before the window closes: a design that let the card reset through early, or stopped the clock on host reset after the window, would be caught. Supply loss is tested with the session command still low. A design that restarted at once, or cleared the fault indication too early, would show the supply enable or status going high.

// File: rtl/sc_act_pkg.sv
package sc_act_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RAMP,
      ST_IOUP,
      ST_CLKUP,
      ST_WIN,
      ST_RUN,
      ST_DN_RST,
      ST_DN_CLK,
      ST_DN_IO,
      ST_HOLD
   } seq_st_e;

   // bit positions on the synchronizer bus
   localparam int SB_PRES  = 0;
   localparam int SB_CMD   = 1;
   localparam int SB_HRST  = 2;
   localparam int SB_SGOOD = 3;
   localparam int SB_VST   = 4;
   localparam int SB_W     = 5;

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
   parameter int                 WIDTH   = 1,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sc_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sc_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain[s] <= RST_VAL;
            else         chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain[s] <= RST_VAL;
            else         chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/sc_act_fsm.sv
module sc_act_fsm
   import sc_act_pkg::*;
#(
   parameter int CLK_DLY_CYC = 25,
   parameter int RST_DLY_CYC = 25,
   parameter int WIN_CYC     = 1000,
   parameter int STEP_CYC    = 25
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pres_s,
   input  logic cmd_s,
   input  logic hrst_s,
   input  logic sgood_s,
   input  logic vst_s,
   output logic vcc_q,
   output logic io_q,
   output logic clk_q,
   output logic card_rst_q,
   output logic stat_o
);

   localparam int M1   = (CLK_DLY_CYC > RST_DLY_CYC) ? CLK_DLY_CYC : RST_DLY_CYC;
   localparam int M2   = (WIN_CYC > STEP_CYC) ? WIN_CYC : STEP_CYC;
   localparam int MAXC = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(MAXC + 1);

   localparam logic [CW-1:0] CLK_END  = CW'(CLK_DLY_CYC - 1);
   localparam logic [CW-1:0] RST_END  = CW'(RST_DLY_CYC - 1);
   localparam logic [CW-1:0] WIN_END  = CW'(WIN_CYC - 1);
   localparam logic [CW-1:0] STEP_END = CW'(STEP_CYC - 1);

   if (CLK_DLY_CYC < 1 || RST_DLY_CYC < 1 || STEP_CYC < 1) begin : g_bad_dly
      $error("sc_act_fsm: delays must be at least one cycle");
   end
   if (WIN_CYC < 4) begin : g_bad_win
      $error("sc_act_fsm: window must be at least four cycles");
   end

   seq_st_e       st;
   logic [CW-1:0] cnt;
   logic          mode_q;
   logic          hrst_d;
   logic          fault_q;
   logic          drop;
   logic          hrst_fall;

   assign drop      = cmd_s | ~sgood_s;
   assign hrst_fall = hrst_d & ~hrst_s;
   assign stat_o    = pres_s & ~fault_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         mode_q     <= 1'b0;
         hrst_d     <= 1'b0;
         fault_q    <= 1'b0;
         vcc_q      <= 1'b0;
         io_q       <= 1'b0;
         clk_q      <= 1'b0;
         card_rst_q <= 1'b0;
      end else begin
         hrst_d <= hrst_s;
         cnt    <= cnt + 1'b1;
         if ((st == ST_RAMP || st == ST_IOUP || st == ST_CLKUP ||
              st == ST_WIN  || st == ST_RUN) && drop) begin
            st         <= ST_DN_RST;
            cnt        <= '0;
            card_rst_q <= 1'b0;
            fault_q    <= ~sgood_s;
         end else begin
            unique case (st)
               ST_IDLE: begin
                  cnt <= '0;
                  if (pres_s && !cmd_s) begin
                     st     <= ST_RAMP;
                     vcc_q  <= 1'b1;
                     mode_q <= hrst_s;
                  end
               end
               ST_RAMP: begin
                  cnt <= '0;
                  if (vst_s) begin
                     io_q <= 1'b1;
                     st   <= mode_q ? ST_WIN : ST_IOUP;
                  end
               end
               ST_IOUP: begin
                  if (cnt == CLK_END) begin
                     clk_q <= 1'b1;
                     cnt   <= '0;
                     st    <= ST_CLKUP;
                  end
               end
               ST_CLKUP: begin
                  if (cnt == RST_END) begin
                     card_rst_q <= hrst_s;
                     cnt        <= '0;
                     st         <= ST_RUN;
                  end
               end
               ST_WIN: begin
                  if (hrst_fall) clk_q <= 1'b1;
                  if (cnt == WIN_END) begin
                     clk_q      <= 1'b1;
                     card_rst_q <= hrst_s;
                     cnt        <= '0;
                     st         <= ST_RUN;
                  end
               end
               ST_RUN: begin
                  cnt        <= '0;
                  card_rst_q <= hrst_s;
               end
               ST_DN_RST: begin
                  if (cnt == STEP_END) begin
                     clk_q <= 1'b0;
                     cnt   <= '0;
                     st    <= ST_DN_CLK;
                  end
               end
               ST_DN_CLK: begin
                  if (cnt == STEP_END) begin
                     io_q <= 1'b0;
                     cnt  <= '0;
                     st   <= ST_DN_IO;
                  end
               end
               ST_DN_IO: begin
                  if (cnt == STEP_END) begin
                     vcc_q <= 1'b0;
                     cnt   <= '0;
                     if (cmd_s) begin
                        st      <= ST_IDLE;
                        fault_q <= 1'b0;
                     end else begin
                        st <= ST_HOLD;
                     end
                  end
               end
               ST_HOLD: begin
                  cnt <= '0;
                  if (cmd_s) begin
                     st      <= ST_IDLE;
                     fault_q <= 1'b0;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   // R9
   clk_needs_io_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_q |-> io_q);
   // R9
   io_needs_vcc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      io_q |-> vcc_q);
   // R9
   rst_needs_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      card_rst_q |-> clk_q);
   // R3
   start_needs_card_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(vcc_q) |-> ($past(pres_s) && !$past(cmd_s)));
   // R4
   io_after_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(io_q) |-> $past(vst_s));
   // R10
   vcc_off_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(vcc_q) |-> (!io_q && !clk_q && !card_rst_q));
   // R8
   win_rst_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_WIN) |-> !card_rst_q);
   // R11
   hold_no_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_HOLD) |-> (!vcc_q && !stat_o));

endmodule

// File: rtl/sc_act_seq.sv
module sc_act_seq
   import sc_act_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CLK_DLY_CYC = 25,
   parameter int RST_DLY_CYC = 25,
   parameter int WIN_CYC     = 1000,
   parameter int STEP_CYC    = 25
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic card_present_i,
   input  logic sess_cmd_ni,
   input  logic supply_good_i,
   input  logic host_rst_i,
   input  logic vcc_stable_i,
   output logic vcc_en_o,
   output logic io_en_o,
   output logic clk_gate_o,
   output logic card_rst_o,
   output logic host_stat_o
);

   localparam logic [SB_W-1:0] SYNC_RST = SB_W'(1) << SB_CMD;

   logic [SB_W-1:0] raw_in;
   logic [SB_W-1:0] syn;

   assign raw_in[SB_PRES]  = card_present_i;
   assign raw_in[SB_CMD]   = sess_cmd_ni;
   assign raw_in[SB_HRST]  = host_rst_i;
   assign raw_in[SB_SGOOD] = supply_good_i;
   assign raw_in[SB_VST]   = vcc_stable_i;

   sc_sync #(
      .WIDTH   (SB_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_in),
      .q_o    (syn)
   );

   sc_act_fsm #(
      .CLK_DLY_CYC (CLK_DLY_CYC),
      .RST_DLY_CYC (RST_DLY_CYC),
      .WIN_CYC     (WIN_CYC),
      .STEP_CYC    (STEP_CYC)
   ) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pres_s     (syn[SB_PRES]),
      .cmd_s      (syn[SB_CMD]),
      .hrst_s     (syn[SB_HRST]),
      .sgood_s    (syn[SB_SGOOD]),
      .vst_s      (syn[SB_VST]),
      .vcc_q      (vcc_en_o),
      .io_q       (io_en_o),
      .clk_q      (clk_gate_o),
      .card_rst_q (card_rst_o),
      .stat_o     (host_stat_o)
   );

endmodule

// File: tb/tb_sc_act_seq.sv
module tb_sc_act_seq;

   localparam int CLK_D = 8;
   localparam int RST_D = 6;
   localparam int WIN   = 40;
   localparam int STEP  = 3;
   localparam int LAT   = 3;
   localparam int TEND  = WIN + 8;
   localparam logic [7:0] NOFALL = 8'hFF;

   typedef struct packed {
      logic       mode;
      logic [7:0] fall;
      logic       fault;
   } scen_t;

   localparam int NSC = 7;
   localparam scen_t SCEN [NSC] = '{
      '{mode: 1'b0, fall: NOFALL,          fault: 1'b0},
      '{mode: 1'b1, fall: 8'd5,            fault: 1'b0},
      '{mode: 1'b1, fall: NOFALL,          fault: 1'b0},
      '{mode: 1'b1, fall: 8'd0,            fault: 1'b0},
      '{mode: 1'b1, fall: 8'(WIN - LAT),   fault: 1'b0},
      '{mode: 1'b0, fall: NOFALL,          fault: 1'b1},
      '{mode: 1'b1, fall: 8'd2,            fault: 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pres = 1'b0, cmd_n = 1'b1, sgood = 1'b1, hrst = 1'b0, vst = 1'b0;
   logic vcc_en, io_en, clk_gate, card_rst, stat;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sc_act_seq #(
      .SYNC_STAGES (2),
      .CLK_DLY_CYC (CLK_D),
      .RST_DLY_CYC (RST_D),
      .WIN_CYC     (WIN),
      .STEP_CYC    (STEP)
   ) dut (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .card_present_i (pres),
      .sess_cmd_ni    (cmd_n),
      .supply_good_i  (sgood),
      .host_rst_i     (hrst),
      .vcc_stable_i   (vst),
      .vcc_en_o       (vcc_en),
      .io_en_o        (io_en),
      .clk_gate_o     (clk_gate),
      .card_rst_o     (card_rst),
      .host_stat_o    (stat)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // activation up to line enable (R3, R4)
   task automatic bring_up(input logic mode);
      hrst = mode; cmd_n = 1'b1; sgood = 1'b1; vst = 1'b0; pres = 1'b1;
      cyc(6);
      chk("R2 status shows card", stat, 1'b1);
      chk("R1 idle supply off", vcc_en, 1'b0);
      cmd_n = 1'b0;
      cyc(2);
      chk("R3 supply not yet", vcc_en, 1'b0);
      cyc(1);
      chk("R3 supply on", vcc_en, 1'b1);
      for (int i = 0; i < 4; i++) begin
         cyc(1);
         chk("R4 lines wait for stable", io_en, 1'b0);
         chk("R4 clock held low", clk_gate, 1'b0);
         chk("R4 reset held low", card_rst, 1'b0);
      end
      vst = 1'b1;
      cyc(2);
      chk("R4 lines not yet", io_en, 1'b0);
      cyc(1);
      chk("R4 lines on", io_en, 1'b1);
   endtask

   // deactivation (R10, R11)
   task automatic take_down(input logic fault);
      if (fault) sgood = 1'b0; else cmd_n = 1'b1;
      for (int t = 1; t <= LAT + 3*STEP + 1; t++) begin
         cyc(1);
         if (t >= LAT) chk("R10 reset low first", card_rst, 1'b0);
         chk("R10 clock order", clk_gate, logic'(t < LAT + STEP));
         chk("R10 lines order", io_en, logic'(t < LAT + 2*STEP));
         chk("R10 supply last", vcc_en, logic'(t < LAT + 3*STEP));
         if (fault) chk("R11 status on fault", stat, logic'(t < LAT));
         else       chk("R2 status after stop", stat, 1'b1);
      end
      vst = 1'b0;
      if (fault) begin
         cyc(4);
         chk("R11 no restart", vcc_en, 1'b0);
         chk("R11 status low held", stat, 1'b0);
         sgood = 1'b1;
         cyc(4);
         chk("R11 still no restart", vcc_en, 1'b0);
         chk("R11 status low until cmd", stat, 1'b0);
         cmd_n = 1'b1;
         cyc(2);
         chk("R11 status not yet", stat, 1'b0);
         cyc(1);
         chk("R11 status restored", stat, 1'b1);
      end
   endtask

   task automatic run_scen(input scen_t s);
      logic hist [0:TEND];
      int   clk_at;
      int   fall;
      logic exp_rst;
      fall = (s.fall == NOFALL) ? -1 : int'(s.fall);
      if (!s.mode)                             clk_at = CLK_D;
      else if (fall >= 0 && fall + LAT <= WIN) clk_at = fall + LAT;
      else                                     clk_at = WIN;
      bring_up(s.mode);
      for (int t = 0; t <= TEND; t++) begin
         if (t > 0) cyc(1);
         if (!s.mode)
            exp_rst = (t >= CLK_D + RST_D) ? hist[t-LAT] : 1'b0;
         else
            exp_rst = (t >= WIN) ? hist[t-LAT] : 1'b0;
         if (!s.mode) chk("R5 clock after delay", clk_gate, logic'(t >= clk_at));
         else if (t <= WIN) begin
            if (fall >= 0 && fall + LAT <= WIN)
               chk("R6 clock on host reset edge", clk_gate, logic'(t >= clk_at));
            else
               chk("R7 clock at window end", clk_gate, logic'(t >= clk_at));
         end else
            chk("R8 clock ignores host reset", clk_gate, 1'b1);
         if (!s.mode) chk("R5 card reset", card_rst, exp_rst);
         else         chk("R8 card reset", card_rst, exp_rst);
         chk("R9 lines stay on", io_en, 1'b1);
         if (!s.mode) begin
            if (t == 0) hrst = 1'b1;
         end else begin
            if (t == fall) hrst = 1'b0;
            if (fall >= 0 && t == fall + 6 && t < WIN - LAT) hrst = 1'b1;
         end
         if (t == TEND - 4) hrst = 1'b0;
         hist[t] = hrst;
      end
      take_down(s.fault);
   endtask

   initial begin
      int wd;
      wd = 0;
      while (!done) begin
         @(posedge clk);
         wd++;
         if (wd > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000", wd);
            finish_run();
         end
      end
   end

   initial begin
      cyc(3);
      chk("R1 reset supply", vcc_en, 1'b0);
      chk("R1 reset lines", io_en, 1'b0);
      chk("R1 reset clock", clk_gate, 1'b0);
      chk("R1 reset card reset", card_rst, 1'b0);
      rst_n = 1'b1;
      cyc(5);
      chk("R1 idle supply", vcc_en, 1'b0);
      chk("R2 no card status", stat, 1'b0);

      // table walk
      for (int i = 0; i < NSC; i++) begin
         run_scen(SCEN[i]);
         cyc(5);
      end

      // R2 presence tracking, R3 no card no session
      pres = 1'b0;
      cyc(1);
      chk("R2 status lag", stat, 1'b1);
      cyc(1);
      chk("R2 status removed", stat, 1'b0);
      cmd_n = 1'b0;
      for (int i = 0; i < 10; i++) begin
         cyc(1);
         chk("R3 no card no supply", vcc_en, 1'b0);
      end
      pres = 1'b1;
      cyc(2);
      chk("R3 insert lag", vcc_en, 1'b0);
      cyc(1);
      chk("R3 insert starts", vcc_en, 1'b1);

      // R10 stop during ramp, supply never stable
      cyc(5);
      chk("R4 no stable no lines", io_en, 1'b0);
      cmd_n = 1'b1;
      cyc(LAT + 3*STEP - 1);
      chk("R10 ramp stop supply held", vcc_en, 1'b1);
      cyc(1);
      chk("R10 ramp stop supply off", vcc_en, 1'b0);

      // R1 reset in mid-session
      bring_up(1'b0);
      cyc(CLK_D + 2);
      chk("R5 clock running", clk_gate, 1'b1);
      rst_n = 1'b0;
      cyc(1);
      chk("R1 mid reset supply", vcc_en, 1'b0);
      chk("R1 mid reset lines", io_en, 1'b0);
      chk("R1 mid reset clock", clk_gate, 1'b0);
      chk("R1 mid reset card reset", card_rst, 1'b0);
      rst_n = 1'b1;
      cmd_n = 1'b1;
      cyc(5);

      done = 1'b1;
      finish_run();
   end

endmodule